// File: doc/BRIEF.md
# Abstract Register Command Sequencer

This block sits in a debug module between the debugger-facing register file and the halted hart. When the debugger writes a register-access command, the block checks it, turns it into two 32-bit instruction words that the hart runs just ahead of the program buffer, and starts the selected hart with a single-cycle `go` pulse. It regards the command as complete when the hart has taken the go and then reports a halt again with its own hart number. Register numbers that fall in a configured custom window are not run on the hart. They are served by a request/response handshake, and the returned value goes into data word 0.

The block owns the command status word. That word holds a busy flag, a sticky error code that software clears by writing 1s, and the fixed sizes of the data area and the program buffer. It also holds the auto-execute masks. Once a mask bit is set, a debugger access to the matching data or program-buffer word re-runs the stored command.

States: `ST_WAIT` (idle), `ST_CHECK` (legality check and word generation), `ST_EXEC` (hart running) and `ST_CUSTOM` (custom register handshake). Transitions:
- WAIT→CHECK on an accepted command write or on an auto-execute hit.
- CHECK→WAIT on an error.
- CHECK→CUSTOM for a custom register number.
- CHECK→EXEC otherwise.
- EXEC→WAIT on completion.
- CUSTOM→WAIT when the handshake fires.

Top module: `abs_cmd_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`=0, `go`=0, `cust_valid`=0, and the error code is 0.
- R2: The command word is laid out as follows: kind [31:24], size [22:20], postexec [18], transfer [17], write [16], regno [15:0]. A command write is accepted only while idle and only while the error code is 0; otherwise the block stays idle and nothing starts. An accepted write stores the command and raises `busy` on the next cycle.
- R3: A command write while `busy` is 1 sets the error code to 1 (busy) if the code was 0. The write is otherwise ignored, and the stored command and generated words stay unchanged.
- R4: The check sets error code 2 (unsupported) and returns to idle in any of these cases: kind is not 0; transfer is 1 with size not equal to 2; transfer is 1 with a regno outside both the GPR range 0x1000–0x101F and the custom window; or transfer is 1 with write 1 on a custom regno.
- R5: If the check passes R4 but `sel_halted` is 0, it sets error code 4 (halt/resume) and returns to idle without pulsing `go`.
- R6: A transfer read whose regno lies in [CUST_LO, CUST_HI] enters the custom state. There `cust_valid` is 1 and `cust_addr` is the regno, and both hold until `cust_ready`. In the cycle of the handshake, `data0_we`=1 and `data0_wdata` equals `cust_rdata`. On the next cycle the block is idle.
- R7: A command that passes the check pulses `go` for exactly the one check cycle, which is the cycle after the write, and then stays busy.
- R8: `abs0` is 0x00000013 (no-op) when transfer is 0. When transfer is 1 and write is 1, it is a word load into x(regno[4:0]) with base x0 and offset DATA_OFF. When transfer is 1 and write is 0, it is a word store of x(regno[4:0]) with base x0 and offset DATA_OFF.
- R9: `abs1` is 0x00000013 when postexec is 1 and 0x00100073 (ebreak) when postexec is 0.
- R10: The running state ends only on a cycle where `halt_wr`=1, `halt_id` equals `sel_hart` and `go_busy`=0. `busy` falls on the next cycle. A halt write from another hart, or one made while `go_busy` is 1, leaves the block busy.
- R11: A write to the status word clears each error bit written as 1 in bits [10:8]. A nonzero error code is never overwritten by a new error.
- R12: While idle with error code 0 and a stored command of kind 0, either of these accesses re-runs the stored command (busy next cycle, `go` in the check cycle): an access to data word i while auto-execute data bit i is set, or an access to program-buffer word j while program-buffer bit j is set. Auto-execute masks are written with data bits at [DATA_WORDS-1:0] and program-buffer bits from bit 16. Other accesses have no effect.
- R13: The status word shows datacount in [3:0], the error code in [10:8], busy in [12] and progbufsize in [28:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| cs_wr | input | 1 | Status word write strobe (error clear) |
| cs_wdata | input | 32 | Status write data, bits [10:8] clear error bits |
| cs_rdata | output | 32 | Status word |
| ae_wr | input | 1 | Auto-execute mask write strobe |
| ae_wdata | input | 32 | Auto-execute masks |
| data_acc | input | 1 | Debugger access to a data word |
| data_idx | input | DIDX_W | Data word index |
| pb_acc | input | 1 | Debugger access to a program-buffer word |
| pb_idx | input | PIDX_W | Program-buffer word index |
| sel_hart | input | HART_W | Currently selected hart |
| sel_halted | input | 1 | Selected hart is halted |
| halt_wr | input | 1 | Hart wrote its number to the halted location |
| halt_id | input | HART_W | Hart number of that write |
| go_busy | input | 1 | Go flag not yet acknowledged by the hart |
| go | output | 1 | Start pulse to the go flag |
| busy | output | 1 | Command in progress |
| abs0 | output | 32 | First generated instruction |
| abs1 | output | 32 | Second generated instruction |
| cust_valid | output | 1 | Custom register request valid |
| cust_addr | output | 16 | Custom register number |
| cust_ready | input | 1 | Custom response valid |
| cust_rdata | input | 32 | Custom response data |
| data0_we | output | 1 | Write enable for data word 0 |
| data0_wdata | output | 32 | Value for data word 0 |

## Verification
The checker watches every cycle for these properties:
- the one-cycle go pulse followed by a busy running state;
- a custom request that holds steady until it is answered and is followed by idle;
- an error code that stays put until a clear write;
- the busy error raised by a command write during a run;
- a second word that is always either a no-op or an ebreak.

The bench scenarios cover the rest: the full instruction encodings for every GPR number and flag mix, each error cause, the completion condition against halt writes from the wrong hart or made before go was taken, and which auto-execute accesses do or do not restart the stored command.

// File: rtl/abs_cmd_pkg.sv
package abs_cmd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_CHECK,
        ST_EXEC,
        ST_CUSTOM
    } ctl_state_t;

    typedef struct packed {
        logic [7:0]  kind;
        logic        rsv;
        logic [2:0]  size;
        logic        postinc;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } reg_cmd_t;

    localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
    localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_HALT  = 3'd4;

    localparam logic [15:0] GPR_BASE = 16'h1000;

endpackage

// File: rtl/abs_insn_gen.sv
module abs_insn_gen
    import abs_cmd_pkg::*;
#(
    parameter logic [11:0] DATA_OFF = 12'h380
) (
    input  reg_cmd_t    cmd,
    output logic [31:0] word0,
    output logic [31:0] word1
);
    localparam logic [6:0] OP_LOAD  = 7'b0000011;
    localparam logic [6:0] OP_STORE = 7'b0100011;
    localparam logic [2:0] F3_WORD  = 3'b010;

    logic [31:0] ld_word;
    logic [31:0] st_word;

    always_comb begin
        ld_word = {DATA_OFF, 5'd0, F3_WORD, cmd.regno[4:0], OP_LOAD};
        st_word = {DATA_OFF[11:5], cmd.regno[4:0], 5'd0, F3_WORD,
                   DATA_OFF[4:0], OP_STORE};
        if (!cmd.transfer)  word0 = INSN_NOP;
        else if (cmd.write) word0 = ld_word;
        else                word0 = st_word;
        word1 = cmd.postexec ? INSN_NOP : INSN_EBREAK;
    end
endmodule

// File: rtl/abs_cmd_check.sv
module abs_cmd_check
    import abs_cmd_pkg::*;
#(
    parameter logic [15:0] CUST_LO = 16'hC000,
    parameter logic [15:0] CUST_HI = 16'hC00F
) (
    input  reg_cmd_t cmd,
    input  logic     hart_halted,
    output logic     unsup,
    output logic     halt_bad,
    output logic     is_custom
);
    logic is_gpr;
    logic in_cust;

    always_comb begin
        is_gpr    = (cmd.regno[15:5] == GPR_BASE[15:5]);
        in_cust   = (cmd.regno >= CUST_LO) && (cmd.regno <= CUST_HI);
        unsup     = (cmd.kind != 8'd0)
                  || (cmd.transfer && (cmd.size != 3'd2))
                  || (cmd.transfer && !is_gpr && !in_cust)
                  || (cmd.transfer && in_cust && cmd.write);
        halt_bad  = !hart_halted;
        is_custom = cmd.transfer && in_cust;
    end
endmodule

// File: rtl/abs_autoexec.sv
module abs_autoexec #(
    parameter int DATA_WORDS    = 2,
    parameter int PROGBUF_WORDS = 4,
    localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int PIDX_W = (PROGBUF_WORDS > 1) ? $clog2(PROGBUF_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ae_wr,
    input  logic [31:0]       ae_wdata,
    input  logic              data_acc,
    input  logic [DIDX_W-1:0] data_idx,
    input  logic              pb_acc,
    input  logic [PIDX_W-1:0] pb_idx,
    output logic              hit
);
    logic [DATA_WORDS-1:0]    dmask_q;
    logic [PROGBUF_WORDS-1:0] pmask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmask_q <= '0;
            pmask_q <= '0;
        end else if (ae_wr) begin
            dmask_q <= ae_wdata[DATA_WORDS-1:0];
            pmask_q <= ae_wdata[16 +: PROGBUF_WORDS];
        end
    end

    always_comb begin
        hit = 1'b0;
        if (data_acc && (int'(data_idx) < DATA_WORDS))
            hit = hit | dmask_q[data_idx];
        if (pb_acc && (int'(pb_idx) < PROGBUF_WORDS))
            hit = hit | pmask_q[pb_idx];
    end
endmodule

// File: rtl/abs_cmd_ctrl.sv
module abs_cmd_ctrl
    import abs_cmd_pkg::*;
#(
    parameter int          NHARTS        = 4,
    parameter int          DATA_WORDS    = 2,
    parameter int          PROGBUF_WORDS = 4,
    parameter logic [11:0] DATA_OFF      = 12'h380,
    parameter logic [15:0] CUST_LO       = 16'hC000,
    parameter logic [15:0] CUST_HI       = 16'hC00F,
    localparam int HART_W = (NHARTS > 1) ? $clog2(NHARTS) : 1,
    localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int PIDX_W = (PROGBUF_WORDS > 1) ? $clog2(PROGBUF_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  logic              cs_wr,
    input  logic [31:0]       cs_wdata,
    output logic [31:0]       cs_rdata,
    input  logic              ae_wr,
    input  logic [31:0]       ae_wdata,
    input  logic              data_acc,
    input  logic [DIDX_W-1:0] data_idx,
    input  logic              pb_acc,
    input  logic [PIDX_W-1:0] pb_idx,
    input  logic [HART_W-1:0] sel_hart,
    input  logic              sel_halted,
    input  logic              halt_wr,
    input  logic [HART_W-1:0] halt_id,
    input  logic              go_busy,
    output logic              go,
    output logic              busy,
    output logic [31:0]       abs0,
    output logic [31:0]       abs1,
    output logic              cust_valid,
    output logic [15:0]       cust_addr,
    input  logic              cust_ready,
    input  logic [31:0]       cust_rdata,
    output logic              data0_we,
    output logic [31:0]       data0_wdata
);
    localparam logic [3:0] DCOUNT = 4'(DATA_WORDS);
    localparam logic [4:0] PBSIZE = 5'(PROGBUF_WORDS);

    ctl_state_t state_q, state_d;
    reg_cmd_t   cmd_q;
    logic [2:0] err_q;
    logic       unsup, halt_bad, is_custom, ae_hit;
    logic       start_wr, start_auto, exec_done;
    logic       set_err;
    logic [2:0] err_code;

    abs_cmd_check #(.CUST_LO(CUST_LO), .CUST_HI(CUST_HI)) u_check (
        .cmd(cmd_q), .hart_halted(sel_halted),
        .unsup(unsup), .halt_bad(halt_bad), .is_custom(is_custom)
    );

    abs_insn_gen #(.DATA_OFF(DATA_OFF)) u_gen (
        .cmd(cmd_q), .word0(abs0), .word1(abs1)
    );

    abs_autoexec #(.DATA_WORDS(DATA_WORDS), .PROGBUF_WORDS(PROGBUF_WORDS)) u_ae (
        .clk(clk), .rst_n(rst_n), .ae_wr(ae_wr), .ae_wdata(ae_wdata),
        .data_acc(data_acc), .data_idx(data_idx),
        .pb_acc(pb_acc), .pb_idx(pb_idx), .hit(ae_hit)
    );

    always_comb begin
        start_wr   = cmd_wr && (state_q == ST_WAIT) && (err_q == ERR_NONE);
        start_auto = !cmd_wr && (state_q == ST_WAIT) && (err_q == ERR_NONE)
                   && ae_hit && (cmd_q.kind == 8'd0);
        exec_done  = halt_wr && (halt_id == sel_hart) && !go_busy;
        state_d    = state_q;
        unique case (state_q)
            ST_WAIT:   if (start_wr || start_auto) state_d = ST_CHECK;
            ST_CHECK: begin
                if (unsup || halt_bad) state_d = ST_WAIT;
                else if (is_custom)    state_d = ST_CUSTOM;
                else                   state_d = ST_EXEC;
            end
            ST_EXEC:   if (exec_done)  state_d = ST_WAIT;
            ST_CUSTOM: if (cust_ready) state_d = ST_WAIT;
            default:   state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        set_err  = 1'b0;
        err_code = ERR_NONE;
        if (cmd_wr && (state_q != ST_WAIT)) begin
            set_err  = 1'b1;
            err_code = ERR_BUSY;
        end else if (state_q == ST_CHECK && unsup) begin
            set_err  = 1'b1;
            err_code = ERR_UNSUP;
        end else if (state_q == ST_CHECK && halt_bad) begin
            set_err  = 1'b1;
            err_code = ERR_HALT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cmd_q   <= '0;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            if (start_wr) cmd_q <= reg_cmd_t'(cmd_wdata);
            if (set_err && err_q == ERR_NONE) err_q <= err_code;
            else if (cs_wr)                   err_q <= err_q & ~cs_wdata[10:8];
        end
    end

    always_comb begin
        busy        = (state_q != ST_WAIT);
        go          = (state_q == ST_CHECK) && !unsup && !halt_bad && !is_custom;
        cust_valid  = (state_q == ST_CUSTOM);
        cust_addr   = cmd_q.regno;
        data0_we    = (state_q == ST_CUSTOM) && cust_ready;
        data0_wdata = cust_rdata;
        cs_rdata    = {3'b000, PBSIZE, 11'd0, busy, 1'b0, err_q, 4'd0, DCOUNT};
    end
endmodule

// File: rtl/abs_cmd_ctrl_chk.sv
module abs_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        cs_wr,
    input logic [31:0] cs_rdata,
    input logic        go,
    input logic        busy,
    input logic [31:0] abs1,
    input logic        cust_valid,
    input logic [15:0] cust_addr,
    input logic        cust_ready
);
    a_r7_go_then_run: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && !go));

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cust_valid && !cust_ready) |=> (cust_valid && $stable(cust_addr)));

    a_r6_req_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cust_valid && cust_ready) |=> !busy);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_rdata[10:8] != 3'd0) && !cs_wr) |=> $stable(cs_rdata[10:8]));

    a_r3_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && (cs_rdata[10:8] == 3'd0)) |=> (cs_rdata[10:8] == 3'd1));

    a_r9_word1_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (abs1 == 32'h0000_0013) || (abs1 == 32'h0010_0073));
endmodule

bind abs_cmd_ctrl abs_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cs_wr(cs_wr),
    .cs_rdata(cs_rdata), .go(go), .busy(busy), .abs1(abs1),
    .cust_valid(cust_valid), .cust_addr(cust_addr), .cust_ready(cust_ready)
);

// File: tb/abs_cmd_ctrl_test.sv
`timescale 1ns/1ps
module abs_cmd_ctrl_test;
    localparam int          NH  = 4;
    localparam int          DW  = 2;
    localparam int          PW  = 4;
    localparam logic [11:0] OFF = 12'h380;
    localparam logic [15:0] CLO = 16'hC000;
    localparam logic [15:0] CHI = 16'hC00F;
    localparam logic [31:0] NOP = 32'h0000_0013;
    localparam logic [31:0] EBK = 32'h0010_0073;
    localparam logic [1:0]  SEL = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0, cs_wr = 0, ae_wr = 0, data_acc = 0, pb_acc = 0;
    logic [31:0] cmd_wdata = 0, cs_wdata = 0, ae_wdata = 0, cust_rdata = 0;
    logic [0:0] data_idx = 0;
    logic [1:0] pb_idx = 0;
    logic [1:0] sel_hart = SEL, halt_id = 0;
    logic sel_halted = 1, halt_wr = 0, go_busy = 0, cust_ready = 0;
    logic [31:0] cs_rdata, abs0, abs1, data0_wdata;
    logic go, busy, cust_valid, data0_we;
    logic [15:0] cust_addr;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    abs_cmd_ctrl #(.NHARTS(NH), .DATA_WORDS(DW), .PROGBUF_WORDS(PW),
                   .DATA_OFF(OFF), .CUST_LO(CLO), .CUST_HI(CHI)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cs_wr(cs_wr), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata),
        .ae_wr(ae_wr), .ae_wdata(ae_wdata), .data_acc(data_acc),
        .data_idx(data_idx), .pb_acc(pb_acc), .pb_idx(pb_idx),
        .sel_hart(sel_hart), .sel_halted(sel_halted), .halt_wr(halt_wr),
        .halt_id(halt_id), .go_busy(go_busy), .go(go), .busy(busy),
        .abs0(abs0), .abs1(abs1), .cust_valid(cust_valid),
        .cust_addr(cust_addr), .cust_ready(cust_ready),
        .cust_rdata(cust_rdata), .data0_we(data0_we),
        .data0_wdata(data0_wdata)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] kind, input logic [2:0] sz,
                                       input bit pe, input bit tr, input bit wr,
                                       input logic [15:0] rn);
        return {kind, 1'b0, sz, 1'b0, pe, tr, wr, rn};
    endfunction

    function automatic logic [31:0] exp_w0(input bit tr, input bit wr, input int r);
        if (!tr) return NOP;
        if (wr) return (32'(OFF) << 20) | (32'd2 << 12) | (32'(r) << 7) | 32'd3;
        return ((32'(OFF) >> 5) << 25) | (32'(r) << 20) | (32'd2 << 12)
             | ((32'(OFF) & 32'd31) << 7) | 32'd35;
    endfunction

    function automatic logic [2:0] err();
        return cs_rdata[10:8];
    endfunction

    task automatic clr_err();
        cs_wr = 1; cs_wdata = 32'h0000_0700;
        step();
        cs_wr = 0; cs_wdata = 0;
    endtask

    task automatic write_cmd(input logic [31:0] c);
        cmd_wr = 1; cmd_wdata = c;
        step();
        cmd_wr = 0;
    endtask

    // Called in the check cycle of a valid command; runs it to completion.
    task automatic finish_exec();
        step();
        halt_wr = 1; halt_id = SEL; go_busy = 0;
        step();
        halt_wr = 0;
    endtask

    task automatic run_exec(input bit tr, input bit wr, input bit pe, input int r);
        write_cmd(mk(8'd0, 3'd2, pe, tr, wr, 16'h1000 + 16'(r)));
        chk(go === 1'b1, "R7 go in check cycle", 32'(go), 1);
        chk(busy === 1'b1, "R2 busy after write", 32'(busy), 1);
        chk(abs0 === exp_w0(tr, wr, r), "R8 abs0", abs0, exp_w0(tr, wr, r));
        chk(abs1 === (pe ? NOP : EBK), "R9 abs1", abs1, pe ? NOP : EBK);
        go_busy = 1;
        step();
        chk(go === 1'b0 && busy === 1'b1, "R7 single go pulse", {go, busy}, 32'd1);
        halt_wr = 1; halt_id = SEL;
        step();
        chk(busy === 1'b1, "R10 halt before go ack ignored", 32'(busy), 1);
        go_busy = 0; halt_id = SEL ^ 2'd1;
        step();
        chk(busy === 1'b1, "R10 other hart ignored", 32'(busy), 1);
        halt_id = SEL;
        step();
        halt_wr = 0;
        chk(busy === 1'b0, "R10 completion", 32'(busy), 0);
    endtask

    logic [31:0] held0;

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 / R13
        chk(busy === 0 && go === 0 && cust_valid === 0, "R1 idle after reset",
            {busy, go, cust_valid}, 0);
        chk(err() === 3'd0, "R1 error clear", 32'(err()), 0);
        chk(cs_rdata === ((32'(PW) << 24) | 32'(DW)), "R13 status layout",
            cs_rdata, (32'(PW) << 24) | 32'(DW));

        // R8/R9/R10 sweep over all flag mixes and GPR numbers
        for (int f = 0; f < 8; f++)
            for (int r = 0; r < 32; r++)
                run_exec(f[2], f[1], f[0], r);

        // R13 busy bit while running, R3 busy error
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1005));
        held0 = abs0;
        chk(cs_rdata[12] === 1'b1, "R13 busy bit", cs_rdata, 32'h1000);
        write_cmd(mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 16'h1009));
        chk(err() === 3'd1, "R3 busy error", 32'(err()), 1);
        chk(abs0 === held0, "R3 stored command kept", abs0, held0);
        halt_wr = 1; halt_id = SEL;
        step();
        halt_wr = 0;
        chk(busy === 0, "R10 done after busy write", 32'(busy), 0);

        // R11: nonzero error blocks new commands, W1C clears
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1000));
        chk(busy === 0 && go === 0, "R2 write refused with error set", {busy, go}, 0);
        cs_wr = 1; cs_wdata = 32'h0000_0600;
        step();
        cs_wr = 0;
        chk(err() === 3'd1, "R11 clear only written bits", 32'(err()), 1);
        clr_err();
        chk(err() === 3'd0, "R11 W1C clear", 32'(err()), 0);

        // R4 unsupported cases
        write_cmd(mk(8'd1, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1000));
        chk(go === 0, "R4 no go for bad kind", 32'(go), 0);
        step();
        chk(busy === 0 && err() === 3'd2, "R4 bad kind", 32'(err()), 2);
        clr_err();
        write_cmd(mk(8'd0, 3'd3, 1'b0, 1'b1, 1'b0, 16'h1000));
        step();
        chk(err() === 3'd2, "R4 bad size", 32'(err()), 2);
        clr_err();
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h2000));
        step();
        chk(err() === 3'd2, "R4 regno out of range", 32'(err()), 2);
        clr_err();
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, CLO));
        step();
        chk(err() === 3'd2, "R4 custom write", 32'(err()), 2);
        clr_err();
        write_cmd(mk(8'd0, 3'd3, 1'b1, 1'b0, 1'b0, 16'h2000));
        chk(go === 1, "R4 no transfer accepts any regno", 32'(go), 1);
        finish_exec();
        chk(busy === 0 && err() === 0, "R4 no-transfer run clean", 32'(err()), 0);

        // R5 hart not halted
        sel_halted = 0;
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1001));
        chk(go === 0, "R5 no go when not halted", 32'(go), 0);
        step();
        chk(busy === 0 && err() === 3'd4, "R5 halt error", 32'(err()), 4);
        sel_halted = 1;
        clr_err();

        // R6 custom handshake
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, CLO + 16'd3));
        chk(go === 0, "R6 no go for custom", 32'(go), 0);
        step();
        chk(cust_valid === 1 && cust_addr === CLO + 16'd3, "R6 request",
            32'(cust_addr), 32'(CLO + 16'd3));
        step();
        chk(cust_valid === 1 && busy === 1, "R6 request held", 32'(cust_valid), 1);
        cust_ready = 1; cust_rdata = 32'hA5C3_1E0F;
        #1;
        chk(data0_we === 1 && data0_wdata === 32'hA5C3_1E0F, "R6 data load",
            data0_wdata, 32'hA5C3_1E0F);
        step();
        cust_ready = 0;
        chk(busy === 0 && cust_valid === 0 && data0_we === 0, "R6 back to idle",
            {busy, cust_valid, data0_we}, 0);

        // R12 autoexec
        write_cmd(mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 16'h1007));
        finish_exec();
        ae_wr = 1; ae_wdata = 32'h0008_0002;
        step();
        ae_wr = 0;
        data_acc = 1; data_idx = 1;
        step();
        data_acc = 0;
        chk(busy === 1 && go === 1, "R12 data hit reruns", {busy, go}, 3);
        chk(abs0 === exp_w0(1, 1, 7), "R12 stored command reused", abs0, exp_w0(1, 1, 7));
        finish_exec();
        data_acc = 1; data_idx = 0;
        step();
        data_acc = 0;
        chk(busy === 0, "R12 data miss", 32'(busy), 0);
        pb_acc = 1; pb_idx = 3;
        step();
        pb_acc = 0;
        chk(busy === 1 && go === 1, "R12 progbuf hit", {busy, go}, 3);
        finish_exec();
        pb_acc = 1; pb_idx = 2;
        step();
        pb_acc = 0;
        chk(busy === 0, "R12 progbuf miss", 32'(busy), 0);
        write_cmd(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h2000));
        step();
        data_acc = 1; data_idx = 1;
        step();
        data_acc = 0;
        chk(busy === 0, "R12 blocked by error", 32'(busy), 0);
        clr_err();
        write_cmd(mk(8'd2, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1000));
        step();
        clr_err();
        data_acc = 1; data_idx = 1;
        step();
        data_acc = 0;
        chk(busy === 0, "R12 blocked by non-register kind", 32'(busy), 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule